// File: doc/BRIEF.md
# I2C Slave Address Decoder and Target Dispatcher

This block sits behind the byte-level receiver of an I2C slave and in front of two targets: an I/O register file and an EEPROM controller. A start pulse arms it for an address byte. It compares the seven address bits with two address families, one per target, and each family takes its lowest bit from a strap pin. After a match it steers the write bytes that follow. A register access takes one command byte, which becomes the register pointer. An EEPROM access takes a high and a low address byte. The remaining write bytes come out as write strobes to the chosen target. The pointer or the EEPROM address steps after each data byte. The byte receiver sends back the acknowledge that the block returns for every byte.

A static configuration input turns on an extended mode. In that mode all seven strap pins form one slave address that both targets share. The first write byte after the address picks the target. If its top bit is clear, the byte is a register command. If its top bit is set, that bit is cleared and the byte becomes the EEPROM high address. A read that follows goes to the target chosen most recently. Stop returns the block to idle. A repeated start returns it to the wait for an address byte. Pointers keep their values across transfers.

Top module: `i2c_addr_dispatch`

## Requirements
- R1: After reset, sel_o is none (2'd0), rd_mode_o, ack_valid_o, ack_o, reg_wr_o and ee_wr_o are 0, reg_ptr_o is 0 and ee_addr_o is 0.
- R2: In normal mode (ext_mode_i = 0), an address byte is split as bits 7:1 = address and bit 0 = direction (1 = read). Address {6'b010000, strap_i[0]} selects the register target (sel_o = 2'd1). Address {6'b101000, strap_i[0]} selects the EEPROM target (sel_o = 2'd2). Every byte gives ack_valid_o one cycle later, with ack_o = 1 when the byte is accepted.
- R3: An address byte that matches no target gets ack_o = 0 and leaves sel_o at none. Until the next start, every later byte gets ack_o = 0 and causes no strobe and no change of reg_ptr_o or ee_addr_o.
- R4: For a register write, the first byte after the address loads reg_ptr_o. Each later byte raises reg_wr_o for one cycle, one cycle after the byte, with wr_data_o equal to the byte and reg_ptr_o equal to the write address. reg_ptr_o then rises by one in the next cycle, wrapping at 8 bits.
- R5: For a normal-mode EEPROM write, the first two bytes load ee_addr_o[15:8] and then ee_addr_o[7:0]. Each later byte raises ee_wr_o in the same way, and ee_addr_o then rises by one, wrapping at 16 bits.
- R6: In extended mode (ext_mode_i = 1), the only acknowledged address is strap_i[6:0]. The two family addresses get ack_o = 0 unless they equal it.
- R7: In extended mode, the first write byte after the address picks the target. If bit 7 is 0, sel_o becomes register and the byte loads reg_ptr_o. If bit 7 is 1, sel_o becomes EEPROM, ee_addr_o[15:8] is loaded with the byte with bit 7 cleared, and the next byte loads ee_addr_o[7:0].
- R8: A matched read sets rd_mode_o = 1. In normal mode sel_o follows the address. In extended mode sel_o is the target chosen last (register after reset). Each rd_byte_done_i pulse raises that target's pointer by one in the next cycle.
- R9: A stop makes sel_o none and rd_mode_o 0 in the next cycle. After that, bytes get ack_o = 0 until a start. A repeated start waits for a new address byte, and the pointers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | Static: shared-address extended mode |
| strap_i | input | 7 | Address strap pins; bit 0 is the low address bit in normal mode |
| start_i | input | 1 | One-cycle pulse: start or repeated start seen |
| stop_i | input | 1 | One-cycle pulse: stop seen |
| byte_valid_i | input | 1 | One-cycle pulse: a byte from the master is in byte_i |
| byte_i | input | 8 | Received byte |
| rd_byte_done_i | input | 1 | One-cycle pulse: a read byte went to the master |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = leave SDA released |
| sel_o | output | 2 | Active target: 0 none, 1 register file, 2 EEPROM |
| rd_mode_o | output | 1 | Active transfer is a read |
| reg_ptr_o | output | 8 | Register pointer |
| ee_addr_o | output | 16 | EEPROM address |
| reg_wr_o | output | 1 | Register write strobe |
| ee_wr_o | output | 1 | EEPROM write strobe |
| wr_data_o | output | 8 | Write data for either strobe |

## Verification
ack_valid_o, ack_o, sel_o, rd_mode_o, the loaded pointer bytes and the write strobes with wr_data_o are all due one clock after the byte pulse. The pointer step after a write comes one clock later still. A read step comes one clock after rd_byte_done_i. Stop and start take effect in the clock after their pulse. The bench drives inputs on the falling edge. A behavioural model steps on each rising edge, and all outputs are compared with it on the next falling edge. Directed checks read the acknowledge and the strobe state on the falling edge just after each byte's rising edge, and read the pointers once the transfer has settled.

// File: rtl/i2c_disp_pkg.sv
package i2c_disp_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_REG  = 2'd1,
      TGT_EEP  = 2'd2
   } tgt_e;

   typedef enum logic [3:0] {
      PH_IDLE  = 4'd0,
      PH_ADDR  = 4'd1,
      PH_SKIP  = 4'd2,
      PH_SEL   = 4'd3,
      PH_CMD   = 4'd4,
      PH_AHI   = 4'd5,
      PH_ALO   = 4'd6,
      PH_WDATA = 4'd7,
      PH_READ  = 4'd8
   } phase_e;

endpackage

// File: rtl/i2c_disp_match.sv
module i2c_disp_match #(
   parameter int          STRAP_W    = 7,
   parameter logic [6:0]  REG_FAMILY = 7'h20,
   parameter logic [6:0]  EEP_FAMILY = 7'h50,
   parameter bit          EXT_EN     = 1'b1
) (
   input  logic               ext_mode_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [6:0]         addr7_i,
   output logic               hit_reg_o,
   output logic               hit_eep_o,
   output logic               hit_shared_o
);

   logic [6:0] reg_addr;
   logic [6:0] eep_addr;
   logic       norm_reg;
   logic       norm_eep;

   assign reg_addr = {REG_FAMILY[6:1], strap_i[0]};
   assign eep_addr = {EEP_FAMILY[6:1], strap_i[0]};
   assign norm_reg = (addr7_i == reg_addr);
   assign norm_eep = (addr7_i == eep_addr);

   generate
      if (EXT_EN) begin : g_ext
         logic [6:0] shared_addr;
         assign shared_addr  = 7'(strap_i);
         assign hit_shared_o = ext_mode_i & (addr7_i == shared_addr);
         assign hit_reg_o    = ~ext_mode_i & norm_reg;
         assign hit_eep_o    = ~ext_mode_i & norm_eep;
      end else begin : g_norm
         logic unused_ext;
         assign unused_ext   = ext_mode_i ^ (^strap_i);
         assign hit_shared_o = 1'b0;
         assign hit_reg_o    = norm_reg;
         assign hit_eep_o    = norm_eep;
      end
   endgenerate

endmodule

// File: rtl/i2c_disp_fsm.sv
module i2c_disp_fsm
   import i2c_disp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       byte_valid_i,
   input  logic [7:0] byte_i,
   input  logic       rd_byte_done_i,
   input  logic       hit_reg_i,
   input  logic       hit_eep_i,
   input  logic       hit_shared_i,
   output logic       ack_valid_o,
   output logic       ack_o,
   output tgt_e       sel_o,
   output logic       rd_mode_o,
   output logic       reg_wr_o,
   output logic       ee_wr_o,
   output logic [7:0] wr_data_o,
   output logic       ptr_ld_o,
   output logic       hi_ld_o,
   output logic       hi_mask_o,
   output logic       lo_ld_o,
   output logic       rd_inc_reg_o,
   output logic       rd_inc_eep_o
);

   phase_e phase_q, phase_d;
   tgt_e   sel_d, last_q, last_d;
   logic   rd_d, ack_v_d, ack_d, rwr_d, ewr_d;
   logic   any_hit;

   assign any_hit = hit_reg_i | hit_eep_i | hit_shared_i;

   always_comb begin
      phase_d      = phase_q;
      sel_d        = sel_o;
      last_d       = last_q;
      rd_d         = rd_mode_o;
      ack_v_d      = 1'b0;
      ack_d        = 1'b0;
      rwr_d        = 1'b0;
      ewr_d        = 1'b0;
      ptr_ld_o     = 1'b0;
      hi_ld_o      = 1'b0;
      hi_mask_o    = 1'b0;
      lo_ld_o      = 1'b0;
      rd_inc_reg_o = 1'b0;
      rd_inc_eep_o = 1'b0;
      if (start_i) begin
         phase_d = PH_ADDR;
         sel_d   = TGT_NONE;
         rd_d    = 1'b0;
      end else if (stop_i) begin
         phase_d = PH_IDLE;
         sel_d   = TGT_NONE;
         rd_d    = 1'b0;
      end else if (byte_valid_i) begin
         ack_v_d = 1'b1;
         unique case (phase_q)
            PH_ADDR: begin
               if (!any_hit) begin
                  phase_d = PH_SKIP;
               end else begin
                  ack_d = 1'b1;
                  if (byte_i[0]) begin
                     rd_d    = 1'b1;
                     phase_d = PH_READ;
                     if (hit_shared_i) begin
                        sel_d = last_q;
                     end else begin
                        sel_d  = hit_reg_i ? TGT_REG : TGT_EEP;
                        last_d = sel_d;
                     end
                  end else if (hit_shared_i) begin
                     phase_d = PH_SEL;
                     sel_d   = TGT_NONE;
                  end else if (hit_reg_i) begin
                     phase_d = PH_CMD;
                     sel_d   = TGT_REG;
                     last_d  = TGT_REG;
                  end else begin
                     phase_d = PH_AHI;
                     sel_d   = TGT_EEP;
                     last_d  = TGT_EEP;
                  end
               end
            end
            PH_SEL: begin
               ack_d = 1'b1;
               if (byte_i[7]) begin
                  hi_ld_o   = 1'b1;
                  hi_mask_o = 1'b1;
                  sel_d     = TGT_EEP;
                  last_d    = TGT_EEP;
                  phase_d   = PH_ALO;
               end else begin
                  ptr_ld_o = 1'b1;
                  sel_d    = TGT_REG;
                  last_d   = TGT_REG;
                  phase_d  = PH_WDATA;
               end
            end
            PH_CMD: begin
               ack_d    = 1'b1;
               ptr_ld_o = 1'b1;
               phase_d  = PH_WDATA;
            end
            PH_AHI: begin
               ack_d   = 1'b1;
               hi_ld_o = 1'b1;
               phase_d = PH_ALO;
            end
            PH_ALO: begin
               ack_d   = 1'b1;
               lo_ld_o = 1'b1;
               phase_d = PH_WDATA;
            end
            PH_WDATA: begin
               ack_d = 1'b1;
               rwr_d = (sel_o == TGT_REG);
               ewr_d = (sel_o == TGT_EEP);
            end
            default: ack_d = 1'b0;
         endcase
      end else if (rd_byte_done_i && phase_q == PH_READ) begin
         rd_inc_reg_o = (sel_o == TGT_REG);
         rd_inc_eep_o = (sel_o == TGT_EEP);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         sel_o       <= TGT_NONE;
         last_q      <= TGT_REG;
         rd_mode_o   <= 1'b0;
         ack_valid_o <= 1'b0;
         ack_o       <= 1'b0;
         reg_wr_o    <= 1'b0;
         ee_wr_o     <= 1'b0;
         wr_data_o   <= 8'h00;
      end else begin
         phase_q     <= phase_d;
         sel_o       <= sel_d;
         last_q      <= last_d;
         rd_mode_o   <= rd_d;
         ack_valid_o <= ack_v_d;
         ack_o       <= ack_d;
         reg_wr_o    <= rwr_d;
         ee_wr_o     <= ewr_d;
         if (rwr_d | ewr_d) wr_data_o <= byte_i;
      end
   end

endmodule

// File: rtl/i2c_disp_ptrs.sv
module i2c_disp_ptrs #(
   parameter int PTR_W     = 8,
   parameter int EE_ADDR_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [7:0]           byte_i,
   input  logic                 ptr_ld_i,
   input  logic                 hi_ld_i,
   input  logic                 hi_mask_i,
   input  logic                 lo_ld_i,
   input  logic                 inc_reg_i,
   input  logic                 inc_eep_i,
   output logic [PTR_W-1:0]     reg_ptr_o,
   output logic [EE_ADDR_W-1:0] ee_addr_o
);

   localparam int HI_W = EE_ADDR_W - 8;

   logic [7:0]      hi_val;
   logic [HI_W-1:0] hi_bits;

   assign hi_val  = hi_mask_i ? {1'b0, byte_i[6:0]} : byte_i;
   assign hi_bits = hi_val[HI_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_ptr_o <= '0;
      end else if (ptr_ld_i) begin
         reg_ptr_o <= byte_i[PTR_W-1:0];
      end else if (inc_reg_i) begin
         reg_ptr_o <= reg_ptr_o + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ee_addr_o <= '0;
      end else if (hi_ld_i) begin
         ee_addr_o[EE_ADDR_W-1:8] <= hi_bits;
      end else if (lo_ld_i) begin
         ee_addr_o[7:0] <= byte_i;
      end else if (inc_eep_i) begin
         ee_addr_o <= ee_addr_o + 1'b1;
      end
   end

endmodule

// File: rtl/i2c_addr_dispatch.sv
module i2c_addr_dispatch
   import i2c_disp_pkg::*;
#(
   parameter int          STRAP_W    = 7,
   parameter int          PTR_W      = 8,
   parameter int          EE_ADDR_W  = 16,
   parameter logic [6:0]  REG_FAMILY = 7'h20,
   parameter logic [6:0]  EEP_FAMILY = 7'h50,
   parameter bit          EXT_EN     = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ext_mode_i,
   input  logic [STRAP_W-1:0]   strap_i,
   input  logic                 start_i,
   input  logic                 stop_i,
   input  logic                 byte_valid_i,
   input  logic [7:0]           byte_i,
   input  logic                 rd_byte_done_i,
   output logic                 ack_valid_o,
   output logic                 ack_o,
   output logic [1:0]           sel_o,
   output logic                 rd_mode_o,
   output logic [PTR_W-1:0]     reg_ptr_o,
   output logic [EE_ADDR_W-1:0] ee_addr_o,
   output logic                 reg_wr_o,
   output logic                 ee_wr_o,
   output logic [7:0]           wr_data_o
);

   generate
      if (STRAP_W != 7) begin : g_bad_strap
         $error("STRAP_W must be 7");
      end
      if (PTR_W < 1 || PTR_W > 8) begin : g_bad_ptr
         $error("PTR_W must lie in 1..8");
      end
      if (EE_ADDR_W < 9 || EE_ADDR_W > 16) begin : g_bad_ee
         $error("EE_ADDR_W must lie in 9..16");
      end
      if (REG_FAMILY[6:1] == EEP_FAMILY[6:1]) begin : g_bad_fam
         $error("address families must differ above bit 0");
      end
   endgenerate

   logic hit_reg, hit_eep, hit_shared;
   logic ptr_ld, hi_ld, hi_mask, lo_ld, rd_inc_reg, rd_inc_eep;
   tgt_e sel;

   i2c_disp_match #(
      .STRAP_W    (STRAP_W),
      .REG_FAMILY (REG_FAMILY),
      .EEP_FAMILY (EEP_FAMILY),
      .EXT_EN     (EXT_EN)
   ) match_i (
      .ext_mode_i   (ext_mode_i),
      .strap_i      (strap_i),
      .addr7_i      (byte_i[7:1]),
      .hit_reg_o    (hit_reg),
      .hit_eep_o    (hit_eep),
      .hit_shared_o (hit_shared)
   );

   i2c_disp_fsm fsm_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .stop_i         (stop_i),
      .byte_valid_i   (byte_valid_i),
      .byte_i         (byte_i),
      .rd_byte_done_i (rd_byte_done_i),
      .hit_reg_i      (hit_reg),
      .hit_eep_i      (hit_eep),
      .hit_shared_i   (hit_shared),
      .ack_valid_o    (ack_valid_o),
      .ack_o          (ack_o),
      .sel_o          (sel),
      .rd_mode_o      (rd_mode_o),
      .reg_wr_o       (reg_wr_o),
      .ee_wr_o        (ee_wr_o),
      .wr_data_o      (wr_data_o),
      .ptr_ld_o       (ptr_ld),
      .hi_ld_o        (hi_ld),
      .hi_mask_o      (hi_mask),
      .lo_ld_o        (lo_ld),
      .rd_inc_reg_o   (rd_inc_reg),
      .rd_inc_eep_o   (rd_inc_eep)
   );

   assign sel_o = sel;

   i2c_disp_ptrs #(
      .PTR_W     (PTR_W),
      .EE_ADDR_W (EE_ADDR_W)
   ) ptrs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_i    (byte_i),
      .ptr_ld_i  (ptr_ld),
      .hi_ld_i   (hi_ld),
      .hi_mask_i (hi_mask),
      .lo_ld_i   (lo_ld),
      .inc_reg_i (rd_inc_reg | reg_wr_o),
      .inc_eep_i (rd_inc_eep | ee_wr_o),
      .reg_ptr_o (reg_ptr_o),
      .ee_addr_o (ee_addr_o)
   );

endmodule

// File: rtl/i2c_addr_dispatch_chk.sv
module i2c_addr_dispatch_chk #(
   parameter int PTR_W     = 8,
   parameter int EE_ADDR_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic                 stop_i,
   input logic                 byte_valid_i,
   input logic                 ack_valid_o,
   input logic                 ack_o,
   input logic [1:0]           sel_o,
   input logic                 rd_mode_o,
   input logic [PTR_W-1:0]     reg_ptr_o,
   input logic [EE_ADDR_W-1:0] ee_addr_o,
   input logic                 reg_wr_o,
   input logic                 ee_wr_o
);

   assert_ack_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_i && !start_i && !stop_i) |=> ack_valid_o);

   assert_no_write_on_nak_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid_o && !ack_o) |-> (!reg_wr_o && !ee_wr_o));

   assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_o && ee_wr_o));

   assert_reg_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> (reg_ptr_o == PTR_W'($past(reg_ptr_o) + 1'b1)));

   assert_ee_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ee_wr_o |=> (ee_addr_o == EE_ADDR_W'($past(ee_addr_o) + 1'b1)));

   assert_read_has_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mode_o |-> (sel_o != 2'd0));

   assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> (sel_o == 2'd0 && !rd_mode_o));

endmodule

bind i2c_addr_dispatch i2c_addr_dispatch_chk #(
   .PTR_W     (PTR_W),
   .EE_ADDR_W (EE_ADDR_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .stop_i       (stop_i),
   .byte_valid_i (byte_valid_i),
   .ack_valid_o  (ack_valid_o),
   .ack_o        (ack_o),
   .sel_o        (sel_o),
   .rd_mode_o    (rd_mode_o),
   .reg_ptr_o    (reg_ptr_o),
   .ee_addr_o    (ee_addr_o),
   .reg_wr_o     (reg_wr_o),
   .ee_wr_o      (ee_wr_o)
);

// File: tb/i2c_addr_dispatch_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_dispatch_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_mode = 1'b0;
   logic [6:0]  strap = 7'h01;
   logic        start = 1'b0, stop = 1'b0, bval = 1'b0, rdone = 1'b0;
   logic [7:0]  bdat = 8'h00;
   logic        ack_valid, ack, rd_mode, reg_wr, ee_wr;
   logic [1:0]  sel;
   logic [7:0]  reg_ptr, wr_data;
   logic [15:0] ee_addr;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   i2c_addr_dispatch dut_i (
      .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode), .strap_i(strap),
      .start_i(start), .stop_i(stop), .byte_valid_i(bval), .byte_i(bdat),
      .rd_byte_done_i(rdone), .ack_valid_o(ack_valid), .ack_o(ack),
      .sel_o(sel), .rd_mode_o(rd_mode), .reg_ptr_o(reg_ptr),
      .ee_addr_o(ee_addr), .reg_wr_o(reg_wr), .ee_wr_o(ee_wr),
      .wr_data_o(wr_data)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // behavioural reference model; phases: 0 idle 1 address 2 ignore 3 choose
   // 4 command 5 high 6 low 7 data 8 read
   int         m_ph;
   int         m_sel, m_last;
   bit         m_rd, m_ackv, m_ack, m_rwr, m_ewr, m_live;
   int         m_ptr, m_ee, m_data;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_sel = 0; m_last = 1; m_rd = 0; m_ackv = 0; m_ack = 0;
         m_rwr = 0; m_ewr = 0; m_ptr = 0; m_ee = 0; m_data = 0; m_live = 1;
      end else begin
         int a;
         if (m_rwr) m_ptr = (m_ptr + 1) % 256;
         if (m_ewr) m_ee = (m_ee + 1) % 65536;
         m_rwr = 0; m_ewr = 0; m_ackv = 0; m_ack = 0;
         a = bdat >> 1;
         if (start) begin
            m_ph = 1; m_sel = 0; m_rd = 0;
         end else if (stop) begin
            m_ph = 0; m_sel = 0; m_rd = 0;
         end else if (bval) begin
            m_ackv = 1;
            if (m_ph == 1) begin
               bit sh, hr, he;
               sh = ext_mode && (a == strap);
               hr = !ext_mode && (a == (32 + strap[0]));
               he = !ext_mode && (a == (80 + strap[0]));
               if (!(sh || hr || he)) m_ph = 2;
               else begin
                  m_ack = 1;
                  if (bdat[0]) begin
                     m_rd = 1; m_ph = 8;
                     if (sh) m_sel = m_last;
                     else begin m_sel = hr ? 1 : 2; m_last = m_sel; end
                  end else if (sh) begin m_ph = 3; m_sel = 0; end
                  else if (hr) begin m_ph = 4; m_sel = 1; m_last = 1; end
                  else begin m_ph = 5; m_sel = 2; m_last = 2; end
               end
            end else if (m_ph == 3) begin
               m_ack = 1;
               if (bdat >= 128) begin
                  m_ee = (m_ee % 256) + 256 * (bdat - 128);
                  m_sel = 2; m_last = 2; m_ph = 6;
               end else begin
                  m_ptr = bdat; m_sel = 1; m_last = 1; m_ph = 7;
               end
            end else if (m_ph == 4) begin
               m_ack = 1; m_ptr = bdat; m_ph = 7;
            end else if (m_ph == 5) begin
               m_ack = 1; m_ee = (m_ee % 256) + 256 * bdat; m_ph = 6;
            end else if (m_ph == 6) begin
               m_ack = 1; m_ee = (m_ee / 256) * 256 + bdat; m_ph = 7;
            end else if (m_ph == 7) begin
               m_ack = 1; m_data = bdat;
               if (m_sel == 1) m_rwr = 1; else m_ewr = 1;
            end
         end else if (rdone && m_ph == 8) begin
            if (m_sel == 1) m_ptr = (m_ptr + 1) % 256;
            else m_ee = (m_ee + 1) % 65536;
         end
      end
   end

   always @(negedge clk) begin
      if (m_live) begin
         check("R2 ack_valid", {31'd0, ack_valid}, {31'd0, m_ackv});
         check("R3 ack", {31'd0, ack}, {31'd0, m_ack});
         check("R2 sel", {30'd0, sel}, m_sel);
         check("R8 rd_mode", {31'd0, rd_mode}, {31'd0, m_rd});
         check("R4 reg_ptr", {24'd0, reg_ptr}, m_ptr);
         check("R5 ee_addr", {16'd0, ee_addr}, m_ee);
         check("R4 reg_wr", {31'd0, reg_wr}, {31'd0, m_rwr});
         check("R5 ee_wr", {31'd0, ee_wr}, {31'd0, m_ewr});
         if (m_rwr || m_ewr) check("R4 wr_data", {24'd0, wr_data}, m_data);
      end
   end

   // values seen one clock after each byte
   logic l_ack, l_rwr, l_ewr;
   logic [7:0] l_data, l_ptr;
   logic [15:0] l_ee;

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk) stop = 1'b1;
      @(negedge clk) stop = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk) begin bval = 1'b1; bdat = b; end
      @(negedge clk) begin
         bval = 1'b0;
         l_ack = ack; l_rwr = reg_wr; l_ewr = ee_wr;
         l_data = wr_data; l_ptr = reg_ptr; l_ee = ee_addr;
      end
      @(negedge clk);
   endtask

   task automatic read_done();
      @(negedge clk) rdone = 1'b1;
      @(negedge clk) rdone = 1'b0;
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 sel", {30'd0, sel}, 0);
      check("R1 ptr", {24'd0, reg_ptr}, 0);
      check("R1 ee", {16'd0, ee_addr}, 0);
      check("R1 flags", {27'd0, ack_valid, ack, rd_mode, reg_wr, ee_wr}, 0);

      // normal register write, strap A0 = 1
      pulse_start();
      send(8'h42);
      check("R2 reg addr ack", {31'd0, l_ack}, 1);
      check("R2 reg sel", {30'd0, sel}, 1);
      send(8'h10);
      send(8'hAA);
      check("R4 strobe", {31'd0, l_rwr}, 1);
      check("R4 data", {24'd0, l_data}, 32'hAA);
      check("R4 addr at strobe", {24'd0, l_ptr}, 32'h10);
      send(8'hBB);
      check("R4 addr second", {24'd0, l_ptr}, 32'h11);
      pulse_stop();
      check("R4 ptr after", {24'd0, reg_ptr}, 32'h12);
      check("R9 sel after stop", {30'd0, sel}, 0);
      send(8'h55);
      check("R9 no ack idle", {31'd0, l_ack}, 0);

      // normal EEPROM write, strap A0 = 0
      @(negedge clk) strap = 7'h00;
      pulse_start();
      send(8'hA0);
      check("R2 eep ack", {31'd0, l_ack}, 1);
      check("R2 eep sel", {30'd0, sel}, 2);
      send(8'h81);
      send(8'hFE);
      send(8'h11);
      check("R5 strobe", {31'd0, l_ewr}, 1);
      check("R5 addr at strobe", {16'd0, l_ee}, 32'h81FE);
      send(8'h22);
      send(8'h33);
      @(negedge clk);
      check("R5 addr after", {16'd0, ee_addr}, 32'h8201);

      // repeated start, unmatched address
      pulse_start();
      send(8'h90);
      check("R3 nak", {31'd0, l_ack}, 0);
      check("R3 sel none", {30'd0, sel}, 0);
      send(8'h77);
      check("R3 later nak", {31'd0, l_ack}, 0);
      check("R3 no strobe", {30'd0, l_rwr, l_ewr}, 0);
      check("R3 ptr kept", {24'd0, reg_ptr}, 32'h12);
      check("R3 ee kept", {16'd0, ee_addr}, 32'h8201);
      pulse_stop();

      // normal register read
      @(negedge clk) strap = 7'h01;
      pulse_start();
      send(8'h43);
      check("R8 rd_mode", {31'd0, rd_mode}, 1);
      check("R8 sel reg", {30'd0, sel}, 1);
      read_done();
      read_done();
      check("R8 ptr steps", {24'd0, reg_ptr}, 32'h14);
      pulse_stop();

      // extended mode, shared address 0x35
      @(negedge clk) begin ext_mode = 1'b1; strap = 7'h35; end
      pulse_start();
      send(8'h42);
      check("R6 family nak", {31'd0, l_ack}, 0);
      pulse_start();
      send(8'h6A);
      check("R6 shared ack", {31'd0, l_ack}, 1);
      send(8'h85);
      check("R7 eep sel", {30'd0, sel}, 2);
      send(8'h10);
      check("R7 masked high", {16'd0, ee_addr}, 32'h0510);
      pulse_start();
      send(8'h6B);
      check("R8 ext read sel", {30'd0, sel}, 2);
      read_done();
      check("R8 ext ee step", {16'd0, ee_addr}, 32'h0511);
      pulse_start();
      send(8'h6A);
      send(8'h22);
      check("R7 reg sel", {30'd0, sel}, 1);
      check("R7 reg ptr", {24'd0, reg_ptr}, 32'h22);
      send(8'h99);
      check("R7 reg write", {31'd0, l_rwr}, 1);
      pulse_stop();
      pulse_start();
      send(8'h6B);
      check("R8 ext read last", {30'd0, sel}, 1);
      pulse_stop();
      repeat (3) @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule